// File: doc/BRIEF.md
# Timestamped Event Logger

This block keeps a small on-chip record of condition events, mostly error reports, raised by several independent module log lanes. A lane that wants to log something raises its request with a payload of zero to three 32-bit words. The logger then writes a one-word header followed by the payload words into a word-wide memory. The header carries the lane number, the payload length and a 24-bit timestamp that the logger takes from its own free-running counter. The requesting module does not supply the timestamp.

All lanes share one write stream. A round-robin arbiter picks one lane at a time. The chosen lane gets a one-cycle acknowledge once its entry is fully stored or has been refused, so a lane never loses a request while another lane is being served. The buffer runs in one of two modes. In ring mode, the oldest whole entries are discarded to make room. In linear mode, recording stops when the buffer is full, and refused entries are counted. A synchronous read port lets control software drain the log one word at a time and see how many words are held. A freeze level holds new entries back while the contents are inspected, and a clear pulse empties the log.

Top module: `event_logger`

## Requirements
- R1: Each entry is one header word followed by its payload words in lane order (word 0 first). The header holds the lane index in bits [31:28], the payload word count (0..3) in bits [27:24] and the timestamp in bits [23:0].
- R2: The timestamp counter starts at 0 after reset and advances by one every cycle. When a second entry is granted right after an entry with c payload words, the two stamps differ by exactly 3+c.
- R3: Lanes that request together are served in rotating order, starting from the lane after the last one served. After reset, lane 0 comes first.
- R4: `lane_ack` is one-hot or zero. It pulses for exactly one cycle to the served lane when that lane's entry is completely stored or has been dropped. A lane holds its request and data until that pulse.
- R5: In ring mode (`ring_mode`=1), an entry that does not fit causes whole oldest entries to be discarded until it fits. It is then stored.
- R6: In linear mode, an entry that does not fit is dropped. The sticky `full` flag is set and `drop_count` goes up by one. While `full` is set, every request is dropped and acknowledged, and the stored words stay unchanged.
- R7: A `clr` pulse empties the log, clears `full` and sets `drop_count` to zero on the next cycle.
- R8: While `freeze` is high no new entry is started. A pending request waits without an acknowledge and is stored after `freeze` falls.
- R9: `rd_data` shows the oldest unread word and `rd_level` the number of stored words. A `rd_pop` pulse removes one word. A pop while `rd_level` is 0 has no effect.
- R10: `rd_level` never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_req | input | NUM_SRC | Per-lane log request, held until acknowledged |
| lane_cnt | input | NUM_SRC*PCW | Per-lane payload word count |
| lane_pay | input | NUM_SRC*PAY_MAX*32 | Per-lane payload words, word 0 in the low bits |
| lane_ack | output | NUM_SRC | One-cycle done pulse to the served lane |
| ring_mode | input | 1 | 1: overwrite oldest entries, 0: stop when full |
| freeze | input | 1 | Holds back new entries while high |
| clr | input | 1 | Empties the log and clears full flag and drop count |
| rd_pop | input | 1 | Removes the word shown on rd_data |
| rd_data | output | 32 | Oldest unread word |
| rd_level | output | LW | Number of stored words |
| full | output | 1 | Sticky linear-mode overflow flag |
| drop_count | output | DROP_W | Saturating count of dropped entries |

## Verification
The assertions assume that each lane keeps its request and payload steady from the cycle it rises until the cycle after its acknowledge. They also assume that software pops only whole entries, so the word at the read pointer is a header whenever eviction looks at it, and that `clr` is pulsed only while no entry is in flight. The bench keeps within these limits. Every lane request comes from one task that waits for the acknowledge before letting go. Reads happen only after all sends have returned and always drain complete entries. The clear pulse is issued only with all lanes quiet.

// File: rtl/logger_pkg.sv
// Shared types and header field sizes for the event logger.
// Assumes the header fields fill exactly one 32-bit word.
package logger_pkg;
    localparam int WORD_W   = 32;
    localparam int HSRC_W   = 4;
    localparam int HCNT_W   = 4;
    localparam int TS_W     = 24;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CHECK = 2'd1,
        S_EVICT = 2'd2,
        S_WRITE = 2'd3
    } log_state_e;
endpackage

// File: rtl/logger_ts.sv
// Free-running timestamp counter. It wraps at 2**W and restarts at 0 on reset.
module logger_ts #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] ts
);
    // advance the stamp every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) ts <= '0;
        else        ts <= ts + W'(1);
    end
endmodule

// File: rtl/logger_rr_arb.sv
// Round-robin picker over N request lines. The search starts at the lane after
// the last lane served; take marks that the current grant was used.
// Assumes take is only high while gnt_valid is high.
module logger_rr_arb #(
    parameter int N = 4,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          gnt_valid,
    output logic [SW-1:0] gnt_idx
);
    logic [SW-1:0] last_q;

    // first requester found scanning upward from last_q+1
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = (int'(last_q) + k) % N;
            if (!gnt_valid && req[cand]) begin
                gnt_valid = 1'b1;
                gnt_idx   = SW'(cand);
            end
        end
    end

    // remember the lane served most recently
    always_ff @(posedge clk) begin
        if (!rst_n)    last_q <= SW'(N - 1);
        else if (take) last_q <= gnt_idx;
    end
endmodule

// File: rtl/logger_store.sv
// Word-wide circular log store with write, pop and whole-entry evict.
// Assumes DEPTH is a power of two, and that write and evict are never high
// in the same cycle. Evict has priority over pop, and clear over everything.
module logger_store #(
    parameter int DEPTH = 16,
    parameter int WW    = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_data,
    input  logic          pop,
    input  logic          evict_en,
    input  logic [LW-1:0] evict_len,
    output logic [WW-1:0] rd_data,
    output logic [LW-1:0] level,
    output logic [LW-1:0] free
);
    logic [WW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          pop_ok;
    logic [LW-1:0] add_n, sub_n;

    assign pop_ok  = pop && (level != '0) && !evict_en;
    assign rd_data = mem[rptr];
    assign free    = LW'(DEPTH) - level;

    // how many words enter and leave this cycle
    always_comb begin
        add_n = wr_en ? LW'(1) : '0;
        if (evict_en)    sub_n = evict_len;
        else if (pop_ok) sub_n = LW'(1);
        else             sub_n = '0;
    end

    // storage array, not reset
    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end

    // pointers and fill level
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (wr_en) wptr <= wptr + AW'(1);
            if (evict_en)    rptr <= rptr + AW'(evict_len);
            else if (pop_ok) rptr <= rptr + AW'(1);
            level <= level + add_n - sub_n;
        end
    end
endmodule

// File: rtl/event_logger.sv
// Timestamped event logger top. It latches one arbitrated lane request, then
// decides to drop it, make room for it or store it, and writes the header and
// payload one word per cycle. Assumes a lane holds its request and data until
// its acknowledge, software pops whole entries, and clr is used only while idle.
module event_logger
    import logger_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DEPTH   = 16,
    parameter int PAY_MAX = 3,
    parameter int DROP_W  = 8,
    localparam int PCW    = $clog2(PAY_MAX + 1),
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            lane_req,
    input  logic [NUM_SRC*PCW-1:0]        lane_cnt,
    input  logic [NUM_SRC*PAY_MAX*32-1:0] lane_pay,
    output logic [NUM_SRC-1:0]            lane_ack,
    input  logic                          ring_mode,
    input  logic                          freeze,
    input  logic                          clr,
    input  logic                          rd_pop,
    output logic [31:0]                   rd_data,
    output logic [LW-1:0]                 rd_level,
    output logic                          full,
    output logic [DROP_W-1:0]             drop_count
);
    localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    log_state_e          state;
    logic                gnt_valid, take;
    logic [SW-1:0]       gnt_idx, src_q;
    logic [PCW-1:0]      cnt_q, idx_q;
    logic [TS_W-1:0]     ts_now, ts_q;
    logic [WORD_W-1:0]   pay_q [PAY_MAX];
    logic [WORD_W-1:0]   wr_word;
    logic [LW-1:0]       free_w, need, evict_len;
    logic                wr_en, evict_en, drop_now, finishing, full_q;
    logic [DROP_W-1:0]   drop_q;
    logic                fsm_idle;

    logger_ts #(.W(TS_W)) u_ts (
        .clk(clk), .rst_n(rst_n), .ts(ts_now)
    );

    logger_rr_arb #(.N(NUM_SRC)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(lane_req), .take(take),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    logger_store #(.DEPTH(DEPTH), .WW(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr_en(wr_en), .wr_data(wr_word),
        .pop(rd_pop), .evict_en(evict_en), .evict_len(evict_len),
        .rd_data(rd_data), .level(rd_level), .free(free_w)
    );

    assign fsm_idle  = (state == S_IDLE);
    assign take      = fsm_idle && !freeze && gnt_valid;
    assign need      = LW'(cnt_q) + LW'(1);
    assign drop_now  = !ring_mode && (full_q || (free_w < need));
    assign wr_en     = (state == S_WRITE);
    assign evict_en  = (state == S_EVICT);
    assign evict_len = LW'(rd_data[27:24]) + LW'(1);
    assign finishing = (wr_en && (idx_q == cnt_q)) ||
                       ((state == S_CHECK) && drop_now);
    assign full       = full_q;
    assign drop_count = drop_q;

    // select the word to write: header at index 0, payload after it
    always_comb begin
        wr_word = {HSRC_W'(src_q), HCNT_W'(cnt_q), ts_q};
        for (int k = 0; k < PAY_MAX; k++) begin
            if (int'(idx_q) == k + 1) wr_word = pay_q[k];
        end
    end

    // acknowledge the served lane when its entry is done or refused
    always_comb begin
        lane_ack = '0;
        if (finishing) lane_ack[src_q] = 1'b1;
    end

    // entry sequencing: latch, decide, evict, write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            src_q <= '0;
            cnt_q <= '0;
            ts_q  <= '0;
            idx_q <= '0;
            for (int k = 0; k < PAY_MAX; k++) pay_q[k] <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (take) begin
                        src_q <= gnt_idx;
                        cnt_q <= lane_cnt[int'(gnt_idx)*PCW +: PCW];
                        ts_q  <= ts_now;
                        for (int k = 0; k < PAY_MAX; k++)
                            pay_q[k] <= lane_pay[(int'(gnt_idx)*PAY_MAX + k)*WORD_W +: WORD_W];
                        state <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    idx_q <= '0;
                    if (drop_now)            state <= S_IDLE;
                    else if (free_w >= need) state <= S_WRITE;
                    else                     state <= S_EVICT;
                end
                S_EVICT: state <= S_CHECK;
                S_WRITE: begin
                    idx_q <= idx_q + PCW'(1);
                    if (idx_q == cnt_q) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // sticky overflow flag and saturating drop counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            full_q <= 1'b0;
            drop_q <= '0;
        end else if ((state == S_CHECK) && drop_now) begin
            full_q <= 1'b1;
            if (drop_q != '1) drop_q <= drop_q + DROP_W'(1);
        end
    end
endmodule

// File: rtl/logger_checker.sv
// Property checker for event_logger, attached by bind below.
// Assumes lanes hold request until acknowledged.
module logger_checker #(
    parameter int NUM_SRC = 4,
    parameter int DEPTH   = 16,
    parameter int DROP_W  = 8,
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] lane_req,
    input logic [NUM_SRC-1:0] lane_ack,
    input logic               ring_mode,
    input logic               freeze,
    input logic               clr,
    input logic [LW-1:0]      rd_level,
    input logic               full,
    input logic [DROP_W-1:0]  drop_count,
    input logic               fsm_idle
);
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lane_ack)); // R4
    AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (lane_ack != '0) |-> ((lane_ack & lane_req) == lane_ack)); // R4
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rd_level <= LW'(DEPTH)); // R10
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (full && !clr) |=> full); // R6
    AST_DROP_LINEAR: assert property (@(posedge clk) disable iff (!rst_n) (!$past(clr) && (drop_count != $past(drop_count))) |-> !$past(ring_mode)); // R6
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (rd_level == '0 && !full && drop_count == '0)); // R7
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (freeze && fsm_idle) |=> fsm_idle); // R8
endmodule

bind event_logger logger_checker #(
    .NUM_SRC(NUM_SRC), .DEPTH(DEPTH), .DROP_W(DROP_W)
) i_logger_checker (
    .clk(clk), .rst_n(rst_n), .lane_req(lane_req), .lane_ack(lane_ack),
    .ring_mode(ring_mode), .freeze(freeze), .clr(clr), .rd_level(rd_level),
    .full(full), .drop_count(drop_count), .fsm_idle(fsm_idle)
);

// File: tb/test_event_logger.sv
// Directed bench for event_logger: one task per scenario, each checking itself.
module test_event_logger;
    localparam int NS = 4;
    localparam int DP = 16;
    localparam int PM = 3;
    localparam int CW = 2;
    localparam int LW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     req = '0;
    logic [NS*CW-1:0]  cnt = '0;
    logic [NS*PM*32-1:0] pay = '0;
    logic [NS-1:0]     ack;
    logic              ring_mode = 1'b0;
    logic              freeze = 1'b0;
    logic              clr = 1'b0;
    logic              rd_pop = 1'b0;
    logic [31:0]       rd_data;
    logic [LW-1:0]     rd_level;
    logic              full;
    logic [7:0]        drop_count;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    event_logger #(.NUM_SRC(NS), .DEPTH(DP), .PAY_MAX(PM), .DROP_W(8)) i_event_logger (
        .clk(clk), .rst_n(rst_n), .lane_req(req), .lane_cnt(cnt), .lane_pay(pay),
        .lane_ack(ack), .ring_mode(ring_mode), .freeze(freeze), .clr(clr),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_level(rd_level),
        .full(full), .drop_count(drop_count)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++; total++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic send(input int lane, input int c, input logic [31:0] p0,
                        input logic [31:0] p1, input logic [31:0] p2);
        @(negedge clk);
        cnt[lane*CW +: CW] = CW'(c);
        pay[(lane*PM+0)*32 +: 32] = p0;
        pay[(lane*PM+1)*32 +: 32] = p1;
        pay[(lane*PM+2)*32 +: 32] = p2;
        req[lane] = 1'b1;
        forever begin
            @(negedge clk);
            if (ack[lane]) break;
        end
        @(posedge clk);
        #1 req[lane] = 1'b0;
        @(negedge clk);
        chk("R4 ack lasts one cycle", 32'(ack[lane]), 32'd0);
    endtask

    task automatic pop(output logic [31:0] w);
        @(negedge clk);
        w = rd_data;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic chk_hdr(input string tag, input logic [31:0] w, input int src, input int c);
        chk({tag, " header lane"}, 32'(w[31:28]), 32'(src));
        chk({tag, " header count"}, 32'(w[27:24]), 32'(c));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R9 level after reset", 32'(rd_level), 0);
        chk("R6 full after reset", 32'(full), 0);
        chk("R6 drops after reset", 32'(drop_count), 0);
        chk("R4 no ack after reset", 32'(ack), 0);
    endtask

    task automatic t_first_round;
        logic [31:0] h [4];
        fork
            send(0, 0, 0, 0, 0);
            send(1, 0, 0, 0, 0);
            send(2, 0, 0, 0, 0);
            send(3, 0, 0, 0, 0);
        join
        chk("R9 level after four entries", 32'(rd_level), 4);
        for (int i = 0; i < 4; i++) pop(h[i]);
        for (int i = 0; i < 4; i++) chk_hdr("R3 order after reset", h[i], i, 0);
        for (int i = 1; i < 4; i++) chk("R2 stamp step", 32'(h[i][23:0] - h[i-1][23:0]), 3);
    endtask

    task automatic t_rotation;
        logic [31:0] h [3];
        logic [31:0] w;
        send(1, 0, 0, 0, 0);
        pop(w);
        chk_hdr("R3 lone lane", w, 1, 0);
        fork
            send(0, 0, 0, 0, 0);
            send(2, 0, 0, 0, 0);
            send(3, 0, 0, 0, 0);
        join
        for (int i = 0; i < 3; i++) pop(h[i]);
        chk("R3 rotation first", 32'(h[0][31:28]), 2);
        chk("R3 rotation second", 32'(h[1][31:28]), 3);
        chk("R3 rotation third", 32'(h[2][31:28]), 0);
    endtask

    task automatic t_payload;
        logic [31:0] w [7];
        fork
            send(2, 3, 32'hA000_0001, 32'hA000_0002, 32'hA000_0003);
            send(0, 2, 32'hB000_0001, 32'hB000_0002, 32'hDEAD_BEEF);
        join
        chk("R1 level with payload", 32'(rd_level), 7);
        for (int i = 0; i < 7; i++) pop(w[i]);
        chk_hdr("R1 first entry", w[0], 2, 3);
        chk("R1 payload 0", w[1], 32'hA000_0001);
        chk("R1 payload 1", w[2], 32'hA000_0002);
        chk("R1 payload 2", w[3], 32'hA000_0003);
        chk_hdr("R1 second entry", w[4], 0, 2);
        chk("R1 payload b0", w[5], 32'hB000_0001);
        chk("R1 payload b1", w[6], 32'hB000_0002);
        chk("R2 stamp step after 3 words", 32'(w[4][23:0] - w[0][23:0]), 6);
    endtask

    task automatic t_freeze;
        logic [31:0] w;
        bit seen;
        seen = 0;
        @(negedge clk);
        freeze = 1'b1;
        fork
            send(1, 0, 0, 0, 0);
            begin
                repeat (8) begin
                    @(negedge clk);
                    if (ack != '0) seen = 1;
                end
                chk("R8 no ack while frozen", 32'(seen), 0);
                chk("R8 nothing stored while frozen", 32'(rd_level), 0);
                freeze = 1'b0;
            end
        join
        chk("R8 stored after release", 32'(rd_level), 1);
        pop(w);
        chk_hdr("R8 released entry", w, 1, 0);
    endtask

    task automatic t_linear;
        logic [31:0] w;
        ring_mode = 1'b0;
        for (int e = 0; e < 4; e++) send(0, 3, 32'(e), 32'(e + 10), 32'(e + 20));
        chk("R10 level at capacity", 32'(rd_level), 16);
        chk("R6 not full yet", 32'(full), 0);
        send(2, 0, 0, 0, 0);
        chk("R6 full after overflow", 32'(full), 1);
        chk("R6 drop counted", 32'(drop_count), 1);
        chk("R6 level unchanged", 32'(rd_level), 16);
        chk_hdr("R6 oldest kept", rd_data, 0, 3);
        pop(w);
        chk("R9 level after pop", 32'(rd_level), 15);
        send(2, 0, 0, 0, 0);
        chk("R6 sticky drop", 32'(drop_count), 2);
        chk("R6 level held while full", 32'(rd_level), 15);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R7 level cleared", 32'(rd_level), 0);
        chk("R7 full cleared", 32'(full), 0);
        chk("R7 drops cleared", 32'(drop_count), 0);
    endtask

    task automatic t_ring;
        logic [31:0] w;
        ring_mode = 1'b1;
        for (int e = 0; e < 4; e++) send(3, 3, 32'(16*e + 1), 32'(16*e + 2), 32'(16*e + 3));
        send(1, 1, 32'h0000_00AB, 0, 0);
        chk("R5 level after eviction", 32'(rd_level), 14);
        chk("R5 no drop in ring", 32'(drop_count), 0);
        for (int e = 1; e < 4; e++) begin
            pop(w);
            chk_hdr("R5 survivor", w, 3, 3);
            for (int j = 1; j <= 3; j++) begin
                pop(w);
                chk("R5 survivor payload", w, 32'(16*e + j));
            end
        end
        pop(w);
        chk_hdr("R5 new entry", w, 1, 1);
        pop(w);
        chk("R5 new payload", w, 32'h0000_00AB);
    endtask

    task automatic t_pop_empty;
        chk("R9 empty before pop", 32'(rd_level), 0);
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        chk("R9 pop on empty ignored", 32'(rd_level), 0);
        send(2, 0, 0, 0, 0);
        chk("R9 level after pop on empty", 32'(rd_level), 1);
        chk_hdr("R9 word after pop on empty", rd_data, 2, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_round();
        t_rotation();
        t_payload();
        t_freeze();
        t_linear();
        t_ring();
        t_pop_empty();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule